// File: doc/BRIEF.md
# Complementary Dead-Band Generator

This block turns a single raw pulse-width-modulated signal into a pair of gate-drive outputs, A and B, for the two switches of a half bridge. It holds back each turn-on edge so that one switch is fully off before the other starts to conduct. There are two separate delays, one for each edge. The rising-edge delay sets how long the input must stay high before A turns on. The falling-edge delay sets how long the input must stay low before B turns on. Both delays are counted in clock cycles, and a typical setting is 20 clocks on each edge.

A two-bit mode input chooses which delay paths are in use, or selects a bypass in which no delay is added. A polarity input sets how B is derived. In the active-high complementary setting, B is the inverse of the falling-edge path. In the other setting, B is that path without inversion. Both outputs are registered, so every result appears at least one clock after the input sample that caused it. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `deadband_pair_gen`

## Requirements
- R1: While reset is asserted, both outputs are low, whatever the input, mode and polarity.
- R2: With mode 2'b00 (bypass), both outputs equal the input sampled one clock earlier. The delays and the polarity have no effect in this mode.
- R3: With rising delay enabled (mode bit 0 set) and a rising delay of D, output A goes high D+1 clocks after the input goes high. D=0 gives a latency of exactly one clock.
- R4: If the input stays high for D clocks or fewer (D being the enabled rising delay), output A does not go high.
- R5: Outside reset, output A is low in every cycle that follows a cycle in which the input was sampled low.
- R6: With falling delay enabled (mode bit 1 set), a falling delay of F and polarity 1, output B goes high F+1 clocks after the input goes low, and goes low one clock after the input goes high.
- R7: With polarity 1, if the input stays low for F clocks or fewer (F being the enabled falling delay), output B stays low.
- R8: With polarity 0 and a non-bypass mode, B is the falling-delay path without inversion. It goes high one clock after the input rises and goes low F+1 clocks after the input falls.
- R9: A delay path whose mode bit is clear acts as a delay of zero. Mode 2'b01 enables only the rising delay, and mode 2'b10 enables only the falling delay.
- R10: With polarity 1 and any non-bypass mode, A and B are never high in the same cycle, for any delay values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; delays are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Bit 0 enables the rising delay and bit 1 the falling delay; 2'b00 selects bypass |
| pol_i | input | 1 | 1 gives an active-high complementary pair (B inverted); 0 leaves B non-inverted |
| rise_dly_i | input | DLY_W | Rising-edge delay in clocks |
| fall_dly_i | input | DLY_W | Falling-edge delay in clocks |
| pwm_i | input | 1 | Raw PWM input |
| out_a_o | output | 1 | Gate output A, driven by the rising-edge-delayed path |
| out_b_o | output | 1 | Gate output B, driven by the falling-edge-delayed path |

## Verification
An input edge that needs no delay shows up at the outputs one clock later. An edge that passes through a delay of N shows up N+1 clocks later. Release from reset takes two further clocks in the synchronizer before the outputs respond. The bench drives inputs on falling clock edges and counts the rising edges up to each check. It samples in the cycle just before an output is due to change and again in the cycle just after, so a result that arrives one clock early or one clock late is caught. Pulses that last exactly the programmed delay are used to check the boundary of the suppression rule.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

  typedef enum logic [1:0] {
    DBP_BYPASS    = 2'b00,
    DBP_RISE_ONLY = 2'b01,
    DBP_FALL_ONLY = 2'b10,
    DBP_FULL      = 2'b11
  } dbp_mode_e;

  localparam int unsigned NUM_PATHS = 2;
  localparam int unsigned PATH_RISE = 0;
  localparam int unsigned PATH_FALL = 1;

endpackage

// File: rtl/dbp_rst_sync.sv
module dbp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dbp_edge_delay.sv
// Qualifying delay: the path moves to QUAL_LVL only after the input has
// been sampled at that level for dly_i+1 consecutive clocks. It moves to
// the opposite level on the first sample of that level.
module dbp_edge_delay #(
  parameter int unsigned DLY_W    = 10,
  parameter logic        QUAL_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             din_i,
  output logic             lvl_nxt_o
);

  localparam logic [DLY_W-1:0] CNT_ONE = {{(DLY_W-1){1'b0}}, 1'b1};

  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             cnt_en;

  always_comb begin
    lvl_d  = lvl_q;
    cnt_d  = '0;
    cnt_en = 1'b1;
    if (din_i != QUAL_LVL) begin
      lvl_d = din_i;
    end else if (cnt_q >= dly_i) begin
      lvl_d  = din_i;
      cnt_en = 1'b0;
    end else begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign lvl_nxt_o = lvl_d;

endmodule

// File: rtl/dbp_out_stage.sv
module dbp_out_stage
  import dbp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  dbp_mode_e mode_i,
  input  logic      inv_b_i,
  input  logic      raw_i,
  input  logic      rise_nxt_i,
  input  logic      fall_nxt_i,
  output logic      out_a_o,
  output logic      out_b_o
);

  logic a_d, b_d;
  logic a_q, b_q;

  always_comb begin
    if (mode_i == DBP_BYPASS) begin
      a_d = raw_i;
      b_d = raw_i;
    end else begin
      a_d = rise_nxt_i;
      b_d = inv_b_i ? ~fall_nxt_i : fall_nxt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign out_a_o = a_q;
  assign out_b_o = b_q;

endmodule

// File: rtl/deadband_pair_gen.sv
module deadband_pair_gen
  import dbp_pkg::*;
#(
  parameter int unsigned DLY_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             pol_i,
  input  logic [DLY_W-1:0] rise_dly_i,
  input  logic [DLY_W-1:0] fall_dly_i,
  input  logic             pwm_i,
  output logic             out_a_o,
  output logic             out_b_o
);

  logic                   rst_sync_n;
  logic [DLY_W-1:0]       dly_req [NUM_PATHS];
  logic [NUM_PATHS-1:0]   path_nxt;
  dbp_mode_e              mode_sel;

  assign dly_req[PATH_RISE] = rise_dly_i;
  assign dly_req[PATH_FALL] = fall_dly_i;
  assign mode_sel           = dbp_mode_e'(mode_i);

  dbp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    localparam logic QUAL = (p == PATH_RISE) ? 1'b1 : 1'b0;
    logic [DLY_W-1:0] eff_dly;

    assign eff_dly = mode_i[p] ? dly_req[p] : '0;

    dbp_edge_delay #(
      .DLY_W    (DLY_W),
      .QUAL_LVL (QUAL)
    ) u_dly (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .dly_i     (eff_dly),
      .din_i     (pwm_i),
      .lvl_nxt_o (path_nxt[p])
    );
  end

  dbp_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mode_i     (mode_sel),
    .inv_b_i    (pol_i),
    .raw_i      (pwm_i),
    .rise_nxt_i (path_nxt[PATH_RISE]),
    .fall_nxt_i (path_nxt[PATH_FALL]),
    .out_a_o    (out_a_o),
    .out_b_o    (out_b_o)
  );

endmodule

// File: rtl/dbp_checker.sv
module dbp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       pol_i,
  input logic       pwm_i,
  input logic       out_a_o,
  input logic       out_b_o
);

  // R10: both high only if the previous cycle was bypass or non-inverted
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (out_a_o && out_b_o && $past(rst_n)) |-> $past(mode_i == 2'b00 || !pol_i));

  // R2: bypass passes the input to both outputs after one clock
  a_r2_bypass_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_i == 2'b00)) |->
      (out_a_o == $past(pwm_i) && out_b_o == $past(pwm_i)));

  // R5: a low input sample forces A low on the next cycle
  a_r5_a_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!pwm_i)) |-> !out_a_o);

  // R6: a high input sample forces inverted B low on the next cycle
  a_r6_b_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pwm_i && pol_i && mode_i != 2'b00)) |-> !out_b_o);

  // R9: with only the falling path enabled, A follows the input undelayed
  a_r9_rise_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_i == 2'b10)) |-> (out_a_o == $past(pwm_i)));

endmodule

bind deadband_pair_gen dbp_checker u_dbp_checker (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .mode_i  (mode_i),
  .pol_i   (pol_i),
  .pwm_i   (pwm_i),
  .out_a_o (out_a_o),
  .out_b_o (out_b_o)
);

// File: tb/deadband_pair_gen_tb_top.sv
module deadband_pair_gen_tb_top;

  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned DLY_W      = 10;
  localparam int unsigned WD_CYCLES  = 20000;

  logic             clk;
  logic             rst_n;
  logic [1:0]       mode;
  logic             pol;
  logic [DLY_W-1:0] rdly;
  logic [DLY_W-1:0] fdly;
  logic             pwm;
  logic             out_a;
  logic             out_b;

  int n_checks = 0;
  int n_fails  = 0;

  deadband_pair_gen #(.DLY_W(DLY_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .pol_i      (pol),
    .rise_dly_i (rdly),
    .fall_dly_i (fdly),
    .pwm_i      (pwm),
    .out_a_o    (out_a),
    .out_b_o    (out_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic settle_low(input logic [1:0] m, input logic p,
                            input int r, input int f);
    mode = m; pol = p; rdly = DLY_W'(r); fdly = DLY_W'(f); pwm = 1'b0;
    step(40);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; mode = 2'b00; pol = 1'b1; rdly = '0; fdly = '0; pwm = 1'b1;
    step(3);
    chk("R1", "A in reset", out_a, 1'b0);
    chk("R1", "B in reset", out_b, 1'b0);
    pwm = 1'b0;
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic t_bypass;
    settle_low(2'b00, 1'b1, 20, 7);
    pwm = 1'b1; step(1);
    chk("R2", "A after rise", out_a, 1'b1);
    chk("R2", "B after rise", out_b, 1'b1);
    pwm = 1'b0; step(1);
    chk("R2", "A after fall", out_a, 1'b0);
    chk("R2", "B after fall", out_b, 1'b0);
  endtask

  task automatic t_full_delays(input int r, input int f);
    settle_low(2'b11, 1'b1, r, f);
    chk("R6", "B steady low input", out_b, 1'b1);
    pwm = 1'b1; step(1);
    chk("R6", "B one clock after rise", out_b, 1'b0);
    chk("R3", "A one clock after rise", out_a, 1'b0);
    step(r - 1);
    chk("R3", "A at D clocks", out_a, 1'b0);
    step(1);
    chk("R3", "A at D+1 clocks", out_a, 1'b1);
    step(5);
    pwm = 1'b0; step(1);
    chk("R5", "A one clock after fall", out_a, 1'b0);
    chk("R6", "B one clock after fall", out_b, 1'b0);
    step(f - 1);
    chk("R6", "B at F clocks", out_b, 1'b0);
    step(1);
    chk("R6", "B at F+1 clocks", out_b, 1'b1);
  endtask

  task automatic t_zero_delay;
    settle_low(2'b11, 1'b1, 0, 0);
    pwm = 1'b1; step(1);
    chk("R3", "A zero delay", out_a, 1'b1);
    chk("R6", "B zero delay rise", out_b, 1'b0);
    pwm = 1'b0; step(1);
    chk("R5", "A zero delay fall", out_a, 1'b0);
    chk("R6", "B zero delay fall", out_b, 1'b1);
  endtask

  task automatic t_short_high(input int r);
    logic seen;
    settle_low(2'b11, 1'b1, r, 3);
    seen = 1'b0;
    pwm = 1'b1;
    for (int i = 0; i < r; i++) begin
      step(1);
      seen = seen | out_a;
    end
    pwm = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step(1);
      seen = seen | out_a;
    end
    chk("R4", "A during pulse of exactly D clocks", seen, 1'b0);
  endtask

  task automatic t_short_low(input int f);
    logic seen;
    settle_low(2'b11, 1'b1, 2, f);
    pwm = 1'b1; step(10);
    chk("R7", "A steady high", out_a, 1'b1);
    seen = 1'b0;
    pwm = 1'b0;
    for (int i = 0; i < f; i++) begin
      step(1);
      seen = seen | out_b;
    end
    pwm = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(1);
      seen = seen | out_b;
    end
    chk("R7", "B during low gap of exactly F clocks", seen, 1'b0);
  endtask

  task automatic t_noninv(input int f);
    settle_low(2'b11, 1'b0, 4, f);
    chk("R8", "B steady low input", out_b, 1'b0);
    pwm = 1'b1; step(1);
    chk("R8", "B one clock after rise", out_b, 1'b1);
    step(6);
    pwm = 1'b0; step(f);
    chk("R8", "B at F clocks after fall", out_b, 1'b1);
    step(1);
    chk("R8", "B at F+1 clocks after fall", out_b, 1'b0);
  endtask

  task automatic t_modes;
    settle_low(2'b01, 1'b1, 20, 7);
    pwm = 1'b1; step(20);
    chk("R9", "rise-only A at D clocks", out_a, 1'b0);
    step(1);
    chk("R9", "rise-only A at D+1 clocks", out_a, 1'b1);
    pwm = 1'b0; step(1);
    chk("R9", "rise-only B ignores falling delay", out_b, 1'b1);
    settle_low(2'b10, 1'b1, 20, 7);
    pwm = 1'b1; step(1);
    chk("R9", "fall-only A ignores rising delay", out_a, 1'b1);
    pwm = 1'b0; step(7);
    chk("R9", "fall-only B at F clocks", out_b, 1'b0);
    step(1);
    chk("R9", "fall-only B at F+1 clocks", out_b, 1'b1);
  endtask

  task automatic t_overlap;
    logic both;
    settle_low(2'b11, 1'b1, 3, 2);
    both = 1'b0;
    for (int i = 1; i <= 60; i++) begin
      pwm = ~pwm;
      for (int j = 0; j < (i % 6) + 1; j++) begin
        step(1);
        both = both | (out_a & out_b);
      end
    end
    chk("R10", "A and B high together", both, 1'b0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_bypass();
    t_full_delays(20, 7);
    t_full_delays(1, 1);
    t_zero_delay();
    t_short_high(20);
    t_short_low(7);
    t_noninv(7);
    t_modes();
    t_overlap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule